// File: doc/BRIEF.md
# Processor Bus to DDR2 Write Bridge

This block is the write path between a processor slave bus and a DDR2 memory controller. On the bus clock it takes single writes and burst writes, returns an address acknowledge and one write acknowledge per accepted beat, and packs the beats into groups of four 32-bit controller entries (16 bytes). Each finished group is handed across to the DDR2 clock domain, which runs at twice the bus rate. There it is pushed as one write command into the controller's address FIFO, together with four entries into the controller's write-data FIFO.

A single write always produces a full group. The addressed word carries the caller's byte enables, inverted into a data mask. The other three entries are padded and fully masked. A burst must start in a 16-byte group, cover whole groups and be at most 128 bytes long. All of its bytes are written, and successive groups go to successive 16-byte addresses. The controller's almost-full flags are wired in but do not affect anything. For a separate read engine, the block also returns the bus read acknowledge one bus cycle after the engine requests it.

The group is handed over with a level-based toggle handshake. The bus side holds the group steady until the DDR2 side has copied it. The bus side stalls its write acknowledges only while a finished group is waiting to be copied.

Top module: `ddr_wr_bridge`

States of the bus-side machine: `B_IDLE` (waiting for a write), `B_FILL` (collecting the remaining beats of a burst group), `B_XFER` (group offered to the DDR2 side). Transitions: `B_IDLE`→`B_XFER` on a single write; `B_IDLE`→`B_FILL` on the first beat of a burst; `B_FILL`→`B_XFER` on the last beat of a group; `B_XFER`→`B_FILL` once the copy is acknowledged inside a burst; `B_XFER`→`B_IDLE` once it is acknowledged after a single write; `B_FILL`→`B_IDLE` when no write is present at a group boundary. States of the DDR2-side machine: `M_IDLE` (no group pending) and `M_PUSH` (four push cycles). Transitions: `M_IDLE`→`M_PUSH` when a new request level is seen; `M_PUSH`→`M_IDLE` after the fourth entry.

## Requirements
- R1: A write is taken only when `bus_sel` and `bus_wr_req` are high and `bus_rnw` is low. Any other combination gives no acknowledge and no FIFO push.
- R2: In the bus cycle after a write's first beat is sampled, `bus_addr_ack` and `bus_wr_ack` are both high for exactly one cycle. `bus_addr_ack` occurs once per transaction. `bus_wr_ack` pulses once per accepted beat and never after the last one.
- R3: Every group gives one address-FIFO push with `af_cmd` = 3'b000 (write) and `af_addr` equal to the group's start address. It also gives four write-data pushes in four consecutive DDR2 cycles, and the first of these coincides with the address push.
- R4: A single write to address A with byte enables E and data D gives group address A with bits [3:0] cleared. D is placed in entry A[3:2] (entry 0 is sent first) with mask ~E. Mask bit 3 and `bus_be[3]` belong to the lowest-addressed byte, `bus_data[31:24]`. The other three entries carry mask 4'hF.
- R5: A burst starting at address A gives groups at (A with bits [3:0] cleared) + 16·g. The beats come out in order, four per group, all with mask 4'h0 whatever `bus_be` holds.
- R6: Bursts of one to eight groups (up to 128 bytes) are each pushed exactly once, with no group lost or repeated across the clock crossing.
- R7: `af_almost_full` and `wdf_almost_full` have no effect on acknowledges or pushes.
- R8: `bus_rd_ack` is high in the bus cycle after `rd_ack_req` was sampled high, and low otherwise.
- R9: While `rst` is high, all acknowledges and both FIFO write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| mem_clk | input | 1 | DDR2 FIFO clock, twice the bus rate |
| rst | input | 1 | Active-high asynchronous reset for both domains |
| bus_sel | input | 1 | Memory selected |
| bus_wr_req | input | 1 | Write request |
| bus_rnw | input | 1 | High for read, low for write |
| bus_burst | input | 1 | Transaction is a burst |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | BUS_W/8 | Byte enables, big-endian |
| bus_data | input | BUS_W | Write data, big-endian |
| rd_ack_req | input | 1 | Read engine asks for a read acknowledge |
| af_almost_full | input | 1 | Address FIFO almost full (ignored) |
| wdf_almost_full | input | 1 | Data FIFO almost full (ignored) |
| af_wren | output | 1 | Address FIFO push |
| af_cmd | output | 3 | Command, always write |
| af_addr | output | ADDR_W | Group start address |
| wdf_wren | output | 1 | Write-data FIFO push |
| wdf_data | output | 32 | Entry data |
| wdf_mask | output | 4 | Entry byte mask, 1 = not written |
| bus_rd_ack | output | 1 | Read acknowledge |
| bus_wr_ack | output | 1 | Write acknowledge per beat |
| bus_addr_ack | output | 1 | Address latched |

## Verification
The bench sweeps every word position against every byte-enable pattern for single writes. It runs bursts of every legal length from one to eight groups from unaligned start addresses, with varying byte enables. A design with swapped lanes or an uninverted mask would put data in the wrong entry or write the padding. One that honoured burst byte enables or skipped the low-bit clearing would show non-zero burst masks or shifted addresses. A broken crossing would lose or repeat groups, which shows up in the exact push counts and the consecutive-cycle spacing. Acknowledge timing is checked beat by beat, so a second address acknowledge or a trailing write acknowledge after the last beat is reported. Read-only, deselected and request-less cycles and raised almost-full flags are checked to leave the outputs unchanged.

// File: rtl/ddr_wb_pkg.sv
package ddr_wb_pkg;
    localparam int GRP_WORDS = 4;
    localparam int WORD_W    = 32;
    localparam int GRP_BYTES = GRP_WORDS * WORD_W / 8;
    localparam int CMD_W     = 3;
    localparam logic [CMD_W-1:0] CMD_WRITE = 3'b000;

    typedef logic [GRP_WORDS-1:0][WORD_W-1:0]  grp_data_t;
    typedef logic [GRP_WORDS-1:0][WORD_W/8-1:0] grp_mask_t;

    typedef enum logic [1:0] {B_IDLE, B_FILL, B_XFER} bus_st_e;
    typedef enum logic {M_IDLE, M_PUSH} mem_st_e;
endpackage

// File: rtl/ddr_wb_sync2.sv
module ddr_wb_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ddr_wb_bus_fsm.sv
module ddr_wb_bus_fsm
    import ddr_wb_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_req,
    input  logic              rnw,
    input  logic              burst,
    input  logic [ADDR_W-1:2] addr,
    input  logic [BUS_W/8-1:0] be,
    input  logic [BUS_W-1:0]  data,
    input  logic              ack_sync,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] grp_addr,
    output grp_data_t         grp_data,
    output grp_mask_t         grp_mask,
    output logic              addr_ack,
    output logic              wr_ack
);
    localparam int BE_W       = BUS_W / 8;
    localparam int WPB        = BUS_W / WORD_W;
    localparam int BEATS      = GRP_WORDS / WPB;
    localparam int BCNT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int MAX_GROUPS = MAX_BYTES / GRP_BYTES;
    localparam int GCNT_W     = $clog2(MAX_GROUPS + 1);
    localparam logic [BCNT_W-1:0] LAST_BEAT = BCNT_W'(BEATS - 1);

    bus_st_e           state, nxt;
    logic [BCNT_W-1:0] beat_cnt;
    logic [GCNT_W-1:0] grp_cnt;
    logic              burst_on;
    logic              hit, xfer_done, single_take;
    logic [1:0]        wbase;

    assign hit       = sel & wr_req & ~rnw;
    assign xfer_done = (ack_sync == req_tgl);

    // Entry index the current beat lands in
    always_comb begin
        single_take = (state == B_IDLE) && !burst;
        if (state == B_IDLE)
            wbase = burst ? 2'd0 : (addr[3:2] & ~2'(WPB - 1));
        else
            wbase = 2'(int'(beat_cnt) * WPB);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            B_IDLE: if (hit) nxt = burst ? B_FILL : B_XFER;
            B_FILL: begin
                if (hit && beat_cnt == LAST_BEAT) nxt = B_XFER;
                else if (!hit && beat_cnt == '0) nxt = B_IDLE;
            end
            B_XFER: if (xfer_done) nxt = burst_on ? B_FILL : B_IDLE;
            default: nxt = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= B_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            req_tgl  <= 1'b0;
            grp_addr <= '0;
            grp_data <= '0;
            grp_mask <= '1;
            addr_ack <= 1'b0;
            wr_ack   <= 1'b0;
            beat_cnt <= '0;
            grp_cnt  <= '0;
            burst_on <= 1'b0;
        end else begin
            addr_ack <= 1'b0;
            wr_ack   <= 1'b0;
            unique case (state)
                B_IDLE: if (hit) begin
                    addr_ack <= 1'b1;
                    wr_ack   <= 1'b1;
                    grp_addr <= {addr[ADDR_W-1:4], 4'b0000};
                    burst_on <= burst;
                    grp_cnt  <= '0;
                    grp_mask <= burst ? '0 : '1;
                    if (burst) beat_cnt <= BCNT_W'(1);
                    else       req_tgl  <= ~req_tgl;
                end
                B_FILL: if (hit) begin
                    wr_ack <= 1'b1;
                    if (beat_cnt == LAST_BEAT) begin
                        beat_cnt <= '0;
                        req_tgl  <= ~req_tgl;
                    end else begin
                        beat_cnt <= beat_cnt + 1'b1;
                    end
                end
                B_XFER: if (xfer_done && burst_on) begin
                    grp_addr <= grp_addr + ADDR_W'(GRP_BYTES);
                    grp_cnt  <= grp_cnt + 1'b1;
                end
                default: ;
            endcase
            if (hit && state != B_XFER) begin
                for (int j = 0; j < WPB; j++) begin
                    grp_data[wbase + 2'(j)] <= data[BUS_W-1-WORD_W*j -: WORD_W];
                    grp_mask[wbase + 2'(j)] <= single_take ? ~be[BE_W-1-4*j -: 4] : 4'h0;
                end
            end
        end
    end

    // R2: an address acknowledge always comes with a write acknowledge
    a_r2_addr_with_wr: assert property (@(posedge clk) disable iff (rst)
        addr_ack |-> wr_ack);
    // R2: one address acknowledge per transaction
    a_r2_addr_ack_once: assert property (@(posedge clk) disable iff (rst)
        addr_ack |=> !addr_ack);
    // R6: an offered group stays frozen until it is copied
    a_r6_hold_group: assert property (@(posedge clk) disable iff (rst)
        (state == B_XFER && $past(state == B_XFER)) |-> ($stable(grp_data) && $stable(grp_addr) && $stable(grp_mask)));
    // R6: a burst never offers more than the allowed number of groups
    a_r6_max_burst: assert property (@(posedge clk) disable iff (rst)
        (state == B_XFER) |-> (grp_cnt < GCNT_W'(MAX_GROUPS)));
endmodule

// File: rtl/ddr_wb_mem_fsm.sv
module ddr_wb_mem_fsm
    import ddr_wb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_sync,
    input  logic [ADDR_W-1:0] grp_addr,
    input  grp_data_t         grp_data,
    input  grp_mask_t         grp_mask,
    output logic              ack_tgl,
    output logic              af_wren,
    output logic [CMD_W-1:0]  af_cmd,
    output logic [ADDR_W-1:0] af_addr,
    output logic              wdf_wren,
    output logic [WORD_W-1:0] wdf_data,
    output logic [WORD_W/8-1:0] wdf_mask
);
    localparam int IDX_W = $clog2(GRP_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_WORDS - 1);

    mem_st_e          state, nxt;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] cp_addr;
    grp_data_t        cp_data;
    grp_mask_t        cp_mask;
    logic             pending;

    assign pending = (req_sync != ack_tgl);

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE: if (pending) nxt = M_PUSH;
            M_PUSH: if (idx == LAST_IDX) nxt = M_IDLE;
            default: nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= M_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ack_tgl <= 1'b0;
            idx     <= '0;
            cp_addr <= '0;
            cp_data <= '0;
            cp_mask <= '1;
        end else begin
            unique case (state)
                M_IDLE: if (pending) begin
                    cp_addr <= grp_addr;
                    cp_data <= grp_data;
                    cp_mask <= grp_mask;
                    ack_tgl <= req_sync;
                    idx     <= '0;
                end
                M_PUSH: idx <= idx + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        af_wren  = (state == M_PUSH) && (idx == '0);
        af_cmd   = CMD_WRITE;
        af_addr  = cp_addr;
        wdf_wren = (state == M_PUSH);
        wdf_data = cp_data[idx];
        wdf_mask = cp_mask[idx];
    end

    // R3: a command push always carries the first data entry
    a_r3_cmd_with_data: assert property (@(posedge clk) disable iff (rst)
        af_wren |-> (wdf_wren && af_cmd == CMD_WRITE));
    // R3: the next cycle continues the same group without a new command
    a_r3_data_follows: assert property (@(posedge clk) disable iff (rst)
        af_wren |=> (wdf_wren && !af_wren));
    // R3: the pushed address is group aligned
    a_r3_aligned_addr: assert property (@(posedge clk) disable iff (rst)
        af_wren |-> (af_addr[3:0] == 4'h0));
endmodule

// File: rtl/ddr_wr_bridge.sv
module ddr_wr_bridge
    import ddr_wb_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 128
) (
    input  logic               bus_clk,
    input  logic               mem_clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr_req,
    input  logic               bus_rnw,
    input  logic               bus_burst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W/8-1:0] bus_be,
    input  logic [BUS_W-1:0]   bus_data,
    input  logic               rd_ack_req,
    input  logic               af_almost_full,
    input  logic               wdf_almost_full,
    output logic               af_wren,
    output logic [2:0]         af_cmd,
    output logic [ADDR_W-1:0]  af_addr,
    output logic               wdf_wren,
    output logic [31:0]        wdf_data,
    output logic [3:0]         wdf_mask,
    output logic               bus_rd_ack,
    output logic               bus_wr_ack,
    output logic               bus_addr_ack
);
    logic              req_tgl, req_sync, ack_tgl, ack_sync;
    logic [ADDR_W-1:0] grp_addr;
    grp_data_t         grp_data;
    grp_mask_t         grp_mask;
    logic              unused_bits;

    // Full flags and byte offset within a word play no part in the write path
    assign unused_bits = ^{af_almost_full, wdf_almost_full, bus_addr[1:0]};

    ddr_wb_bus_fsm #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_bus (
        .clk(bus_clk), .rst(rst),
        .sel(bus_sel), .wr_req(bus_wr_req), .rnw(bus_rnw), .burst(bus_burst),
        .addr(bus_addr[ADDR_W-1:2]), .be(bus_be), .data(bus_data),
        .ack_sync(ack_sync), .req_tgl(req_tgl),
        .grp_addr(grp_addr), .grp_data(grp_data), .grp_mask(grp_mask),
        .addr_ack(bus_addr_ack), .wr_ack(bus_wr_ack)
    );

    ddr_wb_sync2 u_req_sync (.clk(mem_clk), .rst(rst), .d(req_tgl), .q(req_sync));
    ddr_wb_sync2 u_ack_sync (.clk(bus_clk), .rst(rst), .d(ack_tgl), .q(ack_sync));

    ddr_wb_mem_fsm #(.ADDR_W(ADDR_W)) u_mem (
        .clk(mem_clk), .rst(rst), .req_sync(req_sync),
        .grp_addr(grp_addr), .grp_data(grp_data), .grp_mask(grp_mask),
        .ack_tgl(ack_tgl),
        .af_wren(af_wren), .af_cmd(af_cmd), .af_addr(af_addr),
        .wdf_wren(wdf_wren), .wdf_data(wdf_data), .wdf_mask(wdf_mask)
    );

    always_ff @(posedge bus_clk or posedge rst) begin
        if (rst) bus_rd_ack <= 1'b0;
        else     bus_rd_ack <= rd_ack_req;
    end

    // R8: the read acknowledge never appears without a request a cycle earlier
    a_r8_rd_ack_cause: assert property (@(posedge bus_clk) disable iff (rst)
        bus_rd_ack |-> $past(rd_ack_req));
endmodule

// File: tb/ddr_wr_bridge_test.sv
module ddr_wr_bridge_test;
    logic        bus_clk = 1'b0, mem_clk = 1'b0, rst = 1'b1;
    logic        bus_sel = 0, bus_wr_req = 0, bus_rnw = 0, bus_burst = 0;
    logic [31:0] bus_addr = 0, bus_data = 0;
    logic [3:0]  bus_be = 0;
    logic        rd_ack_req = 0, af_almost_full = 0, wdf_almost_full = 0;
    logic        af_wren, wdf_wren, bus_rd_ack, bus_wr_ack, bus_addr_ack;
    logic [2:0]  af_cmd;
    logic [31:0] af_addr, wdf_data;
    logic [3:0]  wdf_mask;

    int checks = 0, fails = 0, bcyc = 0, mcyc = 0;
    int n_af = 0, n_wd = 0;
    logic [2:0]  l_cmd [1024];
    logic [31:0] l_aaddr [1024];
    int          l_at [1024];
    logic [31:0] l_data [1024];
    logic [3:0]  l_mask [1024];
    int          l_wt [1024];

    always #10 bus_clk = ~bus_clk;
    always #5  mem_clk = ~mem_clk;

    ddr_wr_bridge uut (.*);

    // FIFO-side monitor, sampled between DDR2 clock edges
    always @(negedge mem_clk) begin
        mcyc <= mcyc + 1;
        if (af_wren) begin
            l_cmd[n_af % 1024] <= af_cmd; l_aaddr[n_af % 1024] <= af_addr;
            l_at[n_af % 1024] <= mcyc; n_af <= n_af + 1;
        end
        if (wdf_wren) begin
            l_data[n_wd % 1024] <= wdf_data; l_mask[n_wd % 1024] <= wdf_mask;
            l_wt[n_wd % 1024] <= mcyc; n_wd <= n_wd + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge bus_clk) begin
        bcyc <= bcyc + 1;
        if (bcyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", bcyc, 150000);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic idle_bus(input int n);
        for (int i = 0; i < n; i++) @(negedge bus_clk);
    endtask

    task automatic drop_req;
        bus_sel = 0; bus_wr_req = 0; bus_burst = 0; bus_rnw = 0;
    endtask

    task automatic do_single(input logic [31:0] a, input logic [3:0] e, input logic [31:0] d);
        int b_af, b_wd;
        b_af = n_af; b_wd = n_wd;
        bus_sel = 1; bus_wr_req = 1; bus_rnw = 0; bus_burst = 0;
        bus_addr = a; bus_be = e; bus_data = d;
        @(negedge bus_clk);
        chk(bus_addr_ack === 1'b1, "R2 single addr_ack", {31'd0, bus_addr_ack}, 1);
        chk(bus_wr_ack === 1'b1, "R2 single wr_ack", {31'd0, bus_wr_ack}, 1);
        drop_req();
        @(negedge bus_clk);
        chk(bus_wr_ack === 1'b0 && bus_addr_ack === 1'b0, "R2 single ack one cycle",
            {30'd0, bus_addr_ack, bus_wr_ack}, 0);
        idle_bus(10);
        chk(n_af - b_af == 1, "R3 single one command", n_af - b_af, 1);
        chk(n_wd - b_wd == 4, "R3 single four entries", n_wd - b_wd, 4);
        chk(l_cmd[b_af % 1024] == 3'b000, "R3 write opcode", {29'd0, l_cmd[b_af % 1024]}, 0);
        chk(l_aaddr[b_af % 1024] == {a[31:4], 4'h0}, "R4 group address",
            l_aaddr[b_af % 1024], {a[31:4], 4'h0});
        for (int k = 0; k < 4; k++) begin
            logic [3:0] em;
            int w;
            w = (b_wd + k) % 1024;
            em = (k == int'(a[3:2])) ? ~e : 4'hF;
            chk(l_mask[w] == em, "R4 entry mask", {28'd0, l_mask[w]}, {28'd0, em});
            chk(l_wt[w] == l_at[b_af % 1024] + k, "R3 consecutive entries", l_wt[w], l_at[b_af % 1024] + k);
            if (k == int'(a[3:2]))
                chk(l_data[w] == d, "R4 lane data", l_data[w], d);
        end
    endtask

    task automatic do_burst(input logic [31:0] a, input int ngrp, input bit afl);
        int b_af, b_wd, nb;
        b_af = n_af; b_wd = n_wd; nb = ngrp * 4;
        bus_sel = 1; bus_wr_req = 1; bus_rnw = 0; bus_burst = 1; bus_addr = a;
        for (int i = 0; i < nb; i++) begin
            int waited;
            bus_data = {8'hB0 + 8'(ngrp), 8'(i), 16'(i * 37 + ngrp)};
            bus_be = 4'(i);
            af_almost_full = afl & i[0];
            wdf_almost_full = afl;
            waited = 0;
            do begin
                @(negedge bus_clk);
                waited++;
            end while (bus_wr_ack !== 1'b1 && waited < 40);
            chk(waited < 40, "R6 burst beat acknowledged", waited, 1);
            chk(bus_addr_ack === (i == 0), "R2 burst addr_ack once", {31'd0, bus_addr_ack}, {31'd0, i == 0});
        end
        drop_req();
        af_almost_full = 0; wdf_almost_full = 0;
        @(negedge bus_clk);
        chk(bus_wr_ack === 1'b0, "R2 no ack after last beat", {31'd0, bus_wr_ack}, 0);
        idle_bus(14);
        chk(n_af - b_af == ngrp, "R6 group count", n_af - b_af, ngrp);
        chk(n_wd - b_wd == nb, "R6 entry count", n_wd - b_wd, nb);
        for (int g = 0; g < ngrp; g++) begin
            logic [31:0] ea;
            ea = {a[31:4], 4'h0} + 32'(16 * g);
            chk(l_aaddr[(b_af + g) % 1024] == ea, "R5 burst group address", l_aaddr[(b_af + g) % 1024], ea);
            chk(l_cmd[(b_af + g) % 1024] == 3'b000, "R3 burst opcode", {29'd0, l_cmd[(b_af + g) % 1024]}, 0);
        end
        for (int i = 0; i < nb; i++) begin
            logic [31:0] ed;
            int w;
            w = (b_wd + i) % 1024;
            ed = {8'hB0 + 8'(ngrp), 8'(i), 16'(i * 37 + ngrp)};
            chk(l_data[w] == ed, "R5 burst data order", l_data[w], ed);
            chk(l_mask[w] == 4'h0, "R5 burst mask clear", {28'd0, l_mask[w]}, 0);
        end
    endtask

    task automatic no_write(input logic s, input logic wq, input logic rw, input string tag);
        int b_af, b_wd;
        bit acked;
        b_af = n_af; b_wd = n_wd; acked = 0;
        bus_sel = s; bus_wr_req = wq; bus_rnw = rw; bus_burst = 0;
        bus_addr = 32'h40; bus_be = 4'hF; bus_data = 32'hDEADBEEF;
        for (int i = 0; i < 5; i++) begin
            @(negedge bus_clk);
            if (bus_wr_ack === 1'b1 || bus_addr_ack === 1'b1) acked = 1;
        end
        drop_req();
        idle_bus(8);
        chk(!acked, tag, {31'd0, acked}, 0);
        chk(n_af == b_af && n_wd == b_wd, tag, n_af - b_af + n_wd - b_wd, 0);
    endtask

    initial begin
        idle_bus(3);
        // R9: quiet outputs during reset
        chk(bus_wr_ack === 0 && bus_addr_ack === 0 && bus_rd_ack === 0, "R9 acks in reset",
            {29'd0, bus_wr_ack, bus_addr_ack, bus_rd_ack}, 0);
        chk(af_wren === 0 && wdf_wren === 0, "R9 pushes in reset", {30'd0, af_wren, wdf_wren}, 0);
        #3 rst = 1'b0;
        idle_bus(4);
        chk(n_af == 0 && n_wd == 0, "R9 no push after reset", n_af + n_wd, 0);

        // R1: cycles that are not writes
        no_write(1, 1, 1, "R1 read ignored");
        no_write(0, 1, 0, "R1 deselected ignored");
        no_write(1, 0, 0, "R1 no request ignored");

        // R4: every lane against every byte-enable pattern
        for (int w = 0; w < 4; w++)
            for (int e = 0; e < 16; e++)
                do_single(32'h0000_2000 + 32'(w * 4) + 32'(e * 256) + 32'(e % 4),
                          4'(e), 32'h1100_0000 * 32'(w + 1) + 32'(e * 4099));

        // R7: almost-full flags high on a single write
        af_almost_full = 1; wdf_almost_full = 1;
        do_single(32'h0000_5A38, 4'b1010, 32'hCAFE_F00D);
        af_almost_full = 0; wdf_almost_full = 0;

        // R5, R6: every legal burst length from an unaligned start
        for (int g = 1; g <= 8; g++) do_burst(32'h0001_0000 + 32'(g * 512) + 32'h9, g, 1'b0);
        // R7: same with the full flags toggling
        do_burst(32'h0003_0004, 8, 1'b1);
        do_burst(32'h0003_1000, 3, 1'b1);

        // R8: read acknowledge one cycle after the request
        rd_ack_req = 1;
        @(negedge bus_clk);
        rd_ack_req = 0;
        chk(bus_rd_ack === 1'b1, "R8 rd_ack follows request", {31'd0, bus_rd_ack}, 1);
        @(negedge bus_clk);
        chk(bus_rd_ack === 1'b0, "R8 rd_ack single cycle", {31'd0, bus_rd_ack}, 0);
        chk(bus_wr_ack === 1'b0, "R1 rd_ack no write ack", {31'd0, bus_wr_ack}, 0);

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule